// File: doc/BRIEF.md
# SD Host Bus-Master DMA Engine

This block moves data between the card-side data path of an SD/SDIO host controller and system memory. Software programs a direction, an address policy, a start address and a transfer length through 64-bit registers, then starts the engine. It then fetches or stores one 64-bit word per beat on a simple request/grant memory port, and exchanges the same words with the card through two valid/ready streams: one toward the card and one from it.

There are two channels. Channel 0 serves write commands and moves memory contents to the card. Channel 1 serves read commands and moves card data into memory. Each channel has its own hold-in-reset bit, its own completion flag and its own error flag. A shared interrupt line is raised by any flag that software has unmasked. A transfer is always one contiguous, 8-byte-aligned segment. Its length in beats is the block count times the block size divided by eight.

Top module: `sd_dma_engine`

## Requirements
- R1: After reset the interrupt is low, no stream or memory request is active, both status registers (0x840, 0x850) read zero, both mask registers (0x848, 0x858) read 1 in bits 17:16, and the channel reset register (0x830) reads 1 in bits 9:8.
- R2: With mode register (0x820) bit 16 = 0, a write of 1 to bit 0 of the control register (0x828) selects channel 0. The engine then reads memory starting at the transfer address (0x880) and presents each word in order on the card-bound stream.
- R3: With mode bit 16 = 1, a start selects channel 1. The engine accepts words from the card stream and writes each to memory in arrival order.
- R4: Mode bit 0 = 1 advances the memory address by 8 after every beat. Mode bit 0 = 0 keeps every beat at the start address.
- R5: The transfer length in beats is the block count (0x870 bits 31:0) times the block size in bytes (0x870 bits 47:32) divided by 8. When the last beat completes, status1 bit 16 (channel 0) or bit 17 (channel 1) is set.
- R6: A start whose address has any of bits 2:0 set produces no memory or stream activity. It sets status2 bit 16 (channel 0) or bit 17 (channel 1) instead.
- R7: The interrupt is high exactly when some status1 or status2 bit 17:16 is 1 and the matching mask bit is 0.
- R8: A write to a status register ANDs each flag with the written bit. Writing 0 therefore clears all flags, and writing 1 in a position keeps that flag.
- R9: Reset register bit 8 (channel 0) and bit 9 (channel 1) hold a channel while they are 0. Clearing the bit of the running channel stops it at once with no further beat and no flag change. A start on a held channel is ignored. Setting the bit again allows new starts.
- R10: A start written while a transfer is in progress is ignored, even if the mode or address registers have been changed.
- R11: A control write with bit 0 = 0 starts nothing.
- R12: A start with a length of zero beats moves no data and sets the completion flag of the selected channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the addressed register |
| irq | output | 1 | Interrupt, OR of unmasked flags |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW (32) | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_gnt | input | 1 | Memory accepts request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| tx_valid | output | 1 | Card-bound word valid |
| tx_data | output | 64 | Card-bound word |
| tx_ready | input | 1 | Card side accepts word |
| rx_valid | input | 1 | Word from card valid |
| rx_data | input | 64 | Word from card |
| rx_ready | output | 1 | Engine accepts word from card |

## Verification
A corrupted beat counter or address pointer appears on the ports within one beat. It shows up as a word at the wrong memory address, a word out of order on the card stream, or a completion flag set one beat early or late. A channel selection latched wrongly shows on the first beat, because traffic then appears on the opposite stream and the wrong status bit is set. An abort that fails to stop the engine is seen within a cycle as an extra handshake after the reset bit is cleared. A misaligned start that slips through shows as a memory request where none is allowed.

// File: rtl/sdde_pkg.sv
// Shared constants and types for the SD host DMA engine.
// Assumes exactly two channels: 0 = memory to card, 1 = card to memory.
package sdde_pkg;
    localparam int NCH = 2;

    localparam logic [11:0] OFS_MODE = 12'h820;
    localparam logic [11:0] OFS_CTRL = 12'h828;
    localparam logic [11:0] OFS_RST  = 12'h830;
    localparam logic [11:0] OFS_ST1  = 12'h840;
    localparam logic [11:0] OFS_MSK1 = 12'h848;
    localparam logic [11:0] OFS_ST2  = 12'h850;
    localparam logic [11:0] OFS_MSK2 = 12'h858;
    localparam logic [11:0] OFS_LEN  = 12'h870;
    localparam logic [11:0] OFS_ADDR = 12'h880;

    typedef enum logic [2:0] {
        MV_IDLE,
        MV_FETCH,
        MV_WAITD,
        MV_PUSH,
        MV_PULL,
        MV_STORE
    } mv_state_t;
endpackage

// File: rtl/sdde_flag.sv
// One sticky status flag: set by an event, AND-cleared by a register write.
// Assumes an event has priority over a clearing write in the same cycle.
module sdde_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic keep_i,
    output logic q_o
);
    // Hold the flag; set wins over the write mask.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (set_i)  q_o <= 1'b1;
        else if (wr_i)   q_o <= q_o & keep_i;
    end
endmodule

// File: rtl/sdde_regs.sv
// Register file of the DMA engine: mode, control, channel reset, status,
// masks, length and address. It also builds the interrupt.
// Assumes the mover reports done/error as one-cycle pulses tagged by channel.
module sdde_regs
    import sdde_pkg::*;
#(
    parameter int AW     = 32,
    parameter int CNT_W  = 32,
    parameter int BSZ_W  = 16,
    localparam int BEAT_W = CNT_W + BSZ_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       reg_addr,
    input  logic              reg_we,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              done_p,
    input  logic              err_p,
    input  logic              evt_chan,
    output logic              start_p,
    output logic              cfg_chan,
    output logic              cfg_incr,
    output logic [AW-1:0]     cfg_addr,
    output logic [BEAT_W-1:0] cfg_beats,
    output logic [NCH-1:0]    chan_run,
    output logic              irq
);
    logic              mode_chan, mode_incr;
    logic [1:0]        mode_bw;
    logic [NCH-1:0]    run_q, m1_q, m2_q, done_q, err_q;
    logic [AW-1:0]     addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BSZ_W-1:0]  bsz_q;
    logic              wr_st1, wr_st2;

    assign wr_st1 = reg_we && (reg_addr == OFS_ST1);
    assign wr_st2 = reg_we && (reg_addr == OFS_ST2);

    // Capture software writes to the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_chan <= 1'b0;
            mode_incr <= 1'b0;
            mode_bw   <= 2'b00;
            run_q     <= '1;
            m1_q      <= '1;
            m2_q      <= '1;
            addr_q    <= '0;
            cnt_q     <= '0;
            bsz_q     <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_MODE: begin
                    mode_chan <= reg_wdata[16];
                    mode_bw   <= reg_wdata[5:4];
                    mode_incr <= reg_wdata[0];
                end
                OFS_RST:  run_q  <= reg_wdata[9:8];
                OFS_MSK1: m1_q   <= reg_wdata[17:16];
                OFS_MSK2: m2_q   <= reg_wdata[17:16];
                OFS_ADDR: addr_q <= reg_wdata[AW-1:0];
                OFS_LEN: begin
                    cnt_q <= reg_wdata[CNT_W-1:0];
                    bsz_q <= reg_wdata[32 +: BSZ_W];
                end
                default: ;
            endcase
        end
    end

    // One sticky done flag and one sticky error flag per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sdde_flag u_done (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (done_p && (evt_chan == 1'(c))),
            .wr_i   (wr_st1),
            .keep_i (reg_wdata[16+c]),
            .q_o    (done_q[c])
        );
        sdde_flag u_err (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (err_p && (evt_chan == 1'(c))),
            .wr_i   (wr_st2),
            .keep_i (reg_wdata[16+c]),
            .q_o    (err_q[c])
        );
    end

    assign start_p   = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[0];
    assign cfg_chan  = mode_chan;
    assign cfg_incr  = mode_incr;
    assign cfg_addr  = addr_q;
    assign cfg_beats = BEAT_W'(cnt_q) * BEAT_W'(bsz_q[BSZ_W-1:3]);
    assign chan_run  = run_q;
    assign irq       = |(done_q & ~m1_q) || |(err_q & ~m2_q);

    // Return the addressed register; unused bits read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_MODE: begin
                reg_rdata[16]  = mode_chan;
                reg_rdata[5:4] = mode_bw;
                reg_rdata[0]   = mode_incr;
            end
            OFS_RST:  reg_rdata[9:8]   = run_q;
            OFS_ST1:  reg_rdata[17:16] = done_q;
            OFS_MSK1: reg_rdata[17:16] = m1_q;
            OFS_ST2:  reg_rdata[17:16] = err_q;
            OFS_MSK2: reg_rdata[17:16] = m2_q;
            OFS_ADDR: reg_rdata[AW-1:0] = addr_q;
            OFS_LEN: begin
                reg_rdata[CNT_W-1:0]  = cnt_q;
                reg_rdata[32 +: BSZ_W] = bsz_q;
            end
            default: ;
        endcase
    end

    p_done_ch0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_p && !evt_chan) |=> done_q[0]);
    p_done_ch1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_p && evt_chan) |=> done_q[1]);
    p_err_ch0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_p && !evt_chan) |=> err_q[0]);
endmodule

// File: rtl/sdde_mover.sv
// Beat engine: on a start it latches channel, address policy and length.
// Channel 0 fetches memory words and pushes them to the card stream.
// Channel 1 pulls card words and stores them to memory, one beat at a time.
// Assumes one read response per granted read, returned in order.
module sdde_mover
    import sdde_pkg::*;
#(
    parameter int AW     = 32,
    parameter int BEAT_W = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_p,
    input  logic              cfg_chan,
    input  logic              cfg_incr,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [BEAT_W-1:0] cfg_beats,
    input  logic [NCH-1:0]    chan_run,
    output logic              done_p,
    output logic              err_p,
    output logic              evt_chan,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              tx_valid,
    output logic [63:0]       tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [63:0]       rx_data,
    output logic              rx_ready
);
    mv_state_t         state;
    logic              chan_q, incr_q, live;
    logic [AW-1:0]     ptr;
    logic [BEAT_W-1:0] left;
    logic [63:0]       buf_q;
    logic              last;

    assign live = chan_run[chan_q];
    assign last = (left == BEAT_W'(1));

    // Sequence the beats of one transfer and report its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= MV_IDLE;
            chan_q <= 1'b0;
            incr_q <= 1'b0;
            ptr    <= '0;
            left   <= '0;
            buf_q  <= '0;
            done_p <= 1'b0;
            err_p  <= 1'b0;
        end else begin
            done_p <= 1'b0;
            err_p  <= 1'b0;
            if (state != MV_IDLE && !live) begin
                state <= MV_IDLE;
            end else begin
                case (state)
                    MV_IDLE: if (start_p && chan_run[cfg_chan]) begin
                        chan_q <= cfg_chan;
                        incr_q <= cfg_incr;
                        ptr    <= cfg_addr;
                        left   <= cfg_beats;
                        if (cfg_addr[2:0] != 3'd0)   err_p  <= 1'b1;
                        else if (cfg_beats == '0)    done_p <= 1'b1;
                        else state <= cfg_chan ? MV_PULL : MV_FETCH;
                    end
                    MV_FETCH: if (mem_gnt) state <= MV_WAITD;
                    MV_WAITD: if (mem_rvalid) begin
                        buf_q <= mem_rdata;
                        state <= MV_PUSH;
                    end
                    MV_PUSH: if (tx_ready) begin
                        ptr   <= incr_q ? ptr + AW'(8) : ptr;
                        left  <= left - BEAT_W'(1);
                        state <= last ? MV_IDLE : MV_FETCH;
                        done_p <= last;
                    end
                    MV_PULL: if (rx_valid) begin
                        buf_q <= rx_data;
                        state <= MV_STORE;
                    end
                    MV_STORE: if (mem_gnt) begin
                        ptr   <= incr_q ? ptr + AW'(8) : ptr;
                        left  <= left - BEAT_W'(1);
                        state <= last ? MV_IDLE : MV_PULL;
                        done_p <= last;
                    end
                    default: state <= MV_IDLE;
                endcase
            end
        end
    end

    assign mem_req   = live && (state == MV_FETCH || state == MV_STORE);
    assign mem_we    = (state == MV_STORE);
    assign mem_addr  = ptr;
    assign mem_wdata = buf_q;
    assign tx_valid  = live && (state == MV_PUSH);
    assign tx_data   = buf_q;
    assign rx_ready  = live && (state == MV_PULL);
    assign evt_chan  = chan_q;

    p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && live) |=> (tx_valid && $stable(tx_data)));
    p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && live) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != MV_IDLE && !live) |=> (state == MV_IDLE && !done_p));
    p_misalign_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_p |-> (!mem_req && !tx_valid && !rx_ready));
    p_busy_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != MV_IDLE && live && start_p) |=> $stable(chan_q));
endmodule

// File: rtl/sd_dma_engine.sv
// Top of the SD host internal DMA engine: register file plus beat mover.
// Assumes 64-bit data, a single contiguous 8-byte-aligned segment per start.
module sd_dma_engine
    import sdde_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 32,
    parameter int BSZ_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [11:0]   reg_addr,
    input  logic          reg_we,
    input  logic [63:0]   reg_wdata,
    output logic [63:0]   reg_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [63:0]   mem_rdata,
    output logic          tx_valid,
    output logic [63:0]   tx_data,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [63:0]   rx_data,
    output logic          rx_ready
);
    localparam int BEAT_W = CNT_W + BSZ_W - 3;

    logic              start_p, cfg_chan, cfg_incr;
    logic              done_p, err_p, evt_chan;
    logic [AW-1:0]     cfg_addr;
    logic [BEAT_W-1:0] cfg_beats;
    logic [NCH-1:0]    chan_run;

    sdde_regs #(.AW(AW), .CNT_W(CNT_W), .BSZ_W(BSZ_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done_p(done_p), .err_p(err_p), .evt_chan(evt_chan),
        .start_p(start_p), .cfg_chan(cfg_chan), .cfg_incr(cfg_incr),
        .cfg_addr(cfg_addr), .cfg_beats(cfg_beats), .chan_run(chan_run), .irq(irq)
    );

    sdde_mover #(.AW(AW), .BEAT_W(BEAT_W)) u_mover (
        .clk(clk), .rst_n(rst_n),
        .start_p(start_p), .cfg_chan(cfg_chan), .cfg_incr(cfg_incr),
        .cfg_addr(cfg_addr), .cfg_beats(cfg_beats), .chan_run(chan_run),
        .done_p(done_p), .err_p(err_p), .evt_chan(evt_chan),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );
endmodule

// File: tb/sd_dma_engine_test.sv
// Scoreboard bench: driver tasks queue expected beats, a negedge monitor
// pops and compares every handshake the engine makes.
module sd_dma_engine_test;
    localparam int AW = 32;
    localparam logic [11:0] A_MODE = 12'h820, A_CTRL = 12'h828, A_RST = 12'h830,
                            A_ST1 = 12'h840, A_MSK1 = 12'h848, A_ST2 = 12'h850,
                            A_MSK2 = 12'h858, A_LEN = 12'h870, A_ADDR = 12'h880;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic reg_we = 1'b0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic irq, mem_req, mem_we, mem_gnt, tx_valid, rx_ready;
    logic [AW-1:0] mem_addr;
    logic [63:0] mem_wdata, tx_data;
    logic mem_rvalid = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0, gnt_ok = 1'b0;
    logic [63:0] mem_rdata = '0, rx_data = '0;

    always #2 clk = ~clk;

    sd_dma_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    assign mem_gnt = mem_req & gnt_ok;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, tx_cnt = 0, mw_cnt = 0, mr_cnt = 0;
    int tx_mode = 0;          // 0 always ready, 1 periodic stall, 2 held low
    bit loose = 1'b0, rx_took = 1'b0, rd_take = 1'b0;
    int rd_idx = 0, rx_idx = 0, rx_len = 0;
    logic [63:0] mem [64];
    logic [63:0] rx_words [16];
    logic [63:0] exp_tx [$];
    logic [63:0] exp_wd [$];
    logic [AW-1:0] exp_wa [$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: set knobs, then sample handshakes that occur at the next posedge.
    always @(negedge clk) begin
        cyc++;
        if (rx_took) rx_idx++;
        rx_valid = (rx_idx < rx_len) && (cyc % 3 != 0);
        rx_data  = rx_words[rx_idx % 16];
        tx_ready = (tx_mode == 0) || (tx_mode == 1 && cyc % 4 != 3);
        gnt_ok   = (cyc % 5 != 4);
        #1;
        if (tx_valid && tx_ready) begin
            tx_cnt++;
            if (!loose) begin
                if (exp_tx.size() == 0) chk("R2 unexpected tx beat", tx_data, 64'hx);
                else chk("R2 tx word", tx_data, exp_tx.pop_front());
            end
        end
        if (mem_req && mem_gnt && mem_we) begin
            mw_cnt++;
            mem[mem_addr[8:3]] = mem_wdata;
            if (exp_wa.size() == 0) chk("R3 unexpected mem write", 64'(mem_addr), 64'hx);
            else begin
                chk("R4 mem write addr", 64'(mem_addr), 64'(exp_wa.pop_front()));
                chk("R3 mem write data", mem_wdata, exp_wd.pop_front());
            end
        end
        rd_take = mem_req && mem_gnt && !mem_we;
        rd_idx  = int'(mem_addr[8:3]);
        if (rd_take) mr_cnt++;
        rx_took = rx_valid && rx_ready;
    end

    // Memory read responses, one cycle after the grant.
    always @(posedge clk) begin
        mem_rvalid <= rd_take;
        mem_rdata  <= mem[rd_idx];
    end

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_bit(input logic [11:0] a, input int b);
        logic [63:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(a, v);
            if (v[b]) return;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Program and start; queue the expected card-bound words for channel 0.
    task automatic go_tx(input logic [AW-1:0] a, input int beats, input bit incr);
        for (int i = 0; i < beats; i++)
            exp_tx.push_back(mem[(int'(a[8:3]) + (incr ? i : 0)) % 64]);
        wr(A_MODE, 64'h30 | 64'(incr));
        wr(A_ADDR, 64'(a));
        wr(A_LEN, (64'd8 << 32) | 64'(beats));
        wr(A_CTRL, 64'h1);
    endtask

    // Program and start channel 1; queue the expected memory writes.
    task automatic go_rx(input logic [AW-1:0] a, input int beats, input bit incr);
        for (int i = 0; i < beats; i++) begin
            rx_words[i] = 64'hB0B0_0000_0000_0000 + 64'(a) * 16 + 64'(i);
            exp_wa.push_back(a + (incr ? AW'(8 * i) : AW'(0)));
            exp_wd.push_back(rx_words[i]);
        end
        rx_idx = 0; rx_len = beats;
        wr(A_MODE, 64'h10030 | 64'(incr));
        wr(A_ADDR, 64'(a));
        wr(A_LEN, (64'd8 << 32) | 64'(beats));
        wr(A_CTRL, 64'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v;
        int snap, snapr;
        for (int i = 0; i < 64; i++) mem[i] = {32'hC0DE0000 + 32'(i), 32'h10000000 + 32'(i * 3)};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", 64'(irq), 0);
        chk("R1 idle ports", 64'({mem_req, tx_valid, rx_ready}), 0);
        rd(A_MSK1, v); chk("R1 mask1", v, 64'h30000);
        rd(A_MSK2, v); chk("R1 mask2", v, 64'h30000);
        rd(A_RST, v);  chk("R1 reset reg", v, 64'h300);
        rd(A_ST1, v);  chk("R1 status1", v, 0);
        rd(A_ST2, v);  chk("R1 status2", v, 0);

        // R2/R5: channel 0, incrementing, with card-side stalls; 2 blocks x 16 bytes
        tx_mode = 1;
        for (int i = 0; i < 2; i++) exp_tx.push_back(mem[8 + 2 * i]);
        for (int i = 0; i < 2; i++) exp_tx.push_back(mem[9 + 2 * i]);
        exp_tx.delete();
        for (int i = 0; i < 4; i++) exp_tx.push_back(mem[8 + i]);
        wr(A_MODE, 64'h31); wr(A_ADDR, 64'h40);
        wr(A_LEN, (64'd16 << 32) | 64'd2); wr(A_CTRL, 64'h1);
        wait_bit(A_ST1, 16); idle(4);
        rd(A_ST1, v); chk("R5 ch0 done flag", v, 64'h10000);
        chk("R5 ch0 beat count", 64'(tx_cnt), 4);
        chk("R2 tx queue drained", 64'(exp_tx.size()), 0);
        chk("R7 irq masked", 64'(irq), 0);
        wr(A_MSK1, 64'h20000); rd(A_ST1, v);
        chk("R7 irq unmasked done", 64'(irq), 1);
        wr(A_MSK1, 64'h30000);

        // R3/R5/R8: channel 1 incrementing
        tx_mode = 0;
        go_rx(32'h100, 3, 1'b1);
        wait_bit(A_ST1, 17); idle(4);
        rd(A_ST1, v); chk("R5 both done flags", v, 64'h30000);
        chk("R3 write count", 64'(mw_cnt), 3);
        wr(A_ST1, 64'h20000); rd(A_ST1, v); chk("R8 keep bit17", v, 64'h20000);
        wr(A_ST1, 64'h0);     rd(A_ST1, v); chk("R8 clear all", v, 0);

        // R4: channel 1 fixed address, then channel 0 fixed address
        go_rx(32'h80, 2, 1'b0);
        wait_bit(A_ST1, 17); idle(4);
        chk("R4 fixed-address writes", 64'(exp_wa.size()), 0);
        wr(A_ST1, 0);
        go_tx(32'h18, 3, 1'b0);
        wait_bit(A_ST1, 16); idle(4);
        chk("R4 fixed-address reads", 64'(exp_tx.size()), 0);
        wr(A_ST1, 0);

        // R6: misaligned start on channel 0 and channel 1
        snap = tx_cnt + mw_cnt + mr_cnt;
        wr(A_MODE, 64'h31); wr(A_ADDR, 64'h44); wr(A_CTRL, 64'h1);
        idle(20);
        chk("R6 no traffic", 64'(tx_cnt + mw_cnt + mr_cnt), 64'(snap));
        rd(A_ST2, v); chk("R6 ch0 error", v, 64'h10000);
        rd(A_ST1, v); chk("R6 no done", v, 0);
        wr(A_MSK2, 64'h20000); rd(A_ST2, v);
        chk("R7 irq on error", 64'(irq), 1);
        wr(A_ST2, 0); rd(A_ST2, v);
        chk("R8 error cleared", v, 0);
        chk("R7 irq drops", 64'(irq), 0);
        wr(A_MSK2, 64'h30000);
        wr(A_MODE, 64'h10031); wr(A_ADDR, 64'h103); wr(A_CTRL, 64'h1);
        idle(20);
        rd(A_ST2, v); chk("R6 ch1 error", v, 64'h20000);
        chk("R6 ch1 no traffic", 64'(tx_cnt + mw_cnt + mr_cnt), 64'(snap));
        wr(A_ST2, 0);

        // R9: abort mid-transfer, start while held, then release
        loose = 1'b1; tx_mode = 1;
        snap = tx_cnt;
        wr(A_MODE, 64'h31); wr(A_ADDR, 64'h0);
        wr(A_LEN, (64'd320 << 32) | 64'd1); wr(A_CTRL, 64'h1);
        while (tx_cnt < snap + 3) @(negedge clk);
        wr(A_RST, 64'h200);
        snap = tx_cnt; snapr = mr_cnt;
        idle(20);
        chk("R9 no beat after abort", 64'(tx_cnt), 64'(snap));
        rd(A_ST1, v); chk("R9 no done after abort", v, 0);
        rd(A_ST2, v); chk("R9 no error after abort", v, 0);
        wr(A_CTRL, 64'h1); idle(20);
        chk("R9 held start ignored", 64'(tx_cnt + mr_cnt), 64'(snap + snapr + 0) + 64'(mr_cnt - snapr));
        chk("R9 held no tx", 64'(tx_cnt), 64'(snap));
        rd(A_ST1, v); chk("R9 held no done", v, 0);
        wr(A_RST, 64'h300);
        loose = 1'b0; tx_mode = 0;
        go_tx(32'h20, 2, 1'b1);
        wait_bit(A_ST1, 16); idle(4);
        chk("R9 restart works", 64'(exp_tx.size()), 0);
        wr(A_ST1, 0);

        // R10: start while busy is ignored
        tx_mode = 2;
        snap = mw_cnt;
        go_tx(32'h40, 4, 1'b1);
        wr(A_MODE, 64'h10031); wr(A_ADDR, 64'h1C0); wr(A_CTRL, 64'h1);
        tx_mode = 0;
        wait_bit(A_ST1, 16); idle(10);
        rd(A_ST1, v); chk("R10 only ch0 done", v, 64'h10000);
        chk("R10 no ch1 writes", 64'(mw_cnt), 64'(snap));
        chk("R10 ch0 beats intact", 64'(exp_tx.size()), 0);
        wr(A_ST1, 0);

        // R11: control write without the start bit
        snap = tx_cnt + mr_cnt;
        wr(A_MODE, 64'h31); wr(A_ADDR, 64'h0); wr(A_LEN, (64'd8 << 32) | 64'd2);
        wr(A_CTRL, 64'h2); idle(20);
        chk("R11 no traffic", 64'(tx_cnt + mr_cnt), 64'(snap));
        rd(A_ST1, v); chk("R11 no done", v, 0);

        // R12: zero-length start completes at once
        wr(A_LEN, (64'd64 << 32)); wr(A_CTRL, 64'h1); idle(4);
        rd(A_ST1, v); chk("R12 zero-length done", v, 64'h10000);
        chk("R12 zero-length no traffic", 64'(tx_cnt + mr_cnt), 64'(snap));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule